// File: doc/BRIEF.md
# Serial Signed Multiplier

This block multiplies two N-bit two's-complement numbers over several clock cycles, using a single N-bit adder. A one-cycle start strobe captures operand A (the multiplier) and operand B (the multiplicand). Each operand is turned into its unsigned magnitude, and the sign of the result is kept aside as the XOR of the two operand sign bits. An unsigned add-and-shift core then runs once for each multiplier bit. In every step, the lowest bit of the 2N-bit accumulator decides whether the multiplicand is added into the accumulator's upper half. The N+1-bit sum, carry included, is shifted right one place together with the lower half. A final step negates the 2N-bit result when the recorded sign is negative.

The control is a three-state machine. IDLE waits for start; IDLE to RUN happens on start and loads the operands. RUN performs one add-and-shift per cycle; RUN to FIX happens after the Nth iteration. FIX applies the sign and raises done; FIX to IDLE is unconditional. busy is high in RUN and FIX. A new operation may be started in the same cycle that done is high.

Top module: `smul_serial`

## Requirements
- R1: A synchronous active-high reset clears busy, done and product to zero on the next rising edge, including in the middle of an operation.
- R2: start sampled high while busy is low captures op_a and op_b, and busy is high in the following cycle.
- R3: After the capturing edge, busy stays high for exactly N+1 cycles. done is then high for exactly one cycle, which is the first cycle in which busy is low again. busy and done are never high together.
- R4: When done is high, product equals the 2N-bit two's-complement value of signed op_a times signed op_b as captured; its sign is the XOR of the operand sign bits unless the product is zero.
- R5: An operand equal to -2^(N-1) is handled as magnitude 2^(N-1) without overflow (for N=8: -128 x -128 = 16384, -128 x 127 = -16256).
- R6: start while busy is high has no effect: the running operation's result, latency and single done pulse are unchanged.
- R7: product keeps its value from the done cycle until the next accepted start.
- R8: For N=8, 118 x 99 and -118 x -99 both give 11682 (0x2DA2), and 118 x -99 gives -11682 (0xD25E).
- R9: start asserted in the done cycle is accepted, giving back-to-back operations.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Start strobe, accepted only when busy is low |
| op_a | input | N | Multiplier operand, two's complement |
| op_b | input | N | Multiplicand operand, two's complement |
| busy | output | 1 | High while an operation is in RUN or FIX |
| done | output | 1 | One-cycle pulse when product is valid |
| product | output | 2N | Signed 2N-bit product |

## Verification
Operand pairs are chosen in all four sign quadrants, so that a wrong sign rule or a missing final negation shows up as a wrong result. Zero operands and -1 x -1 test the path where the magnitude is zero or one. The most negative value on either input, or on both, tests magnitude conversion at its overflow edge. A long pseudo-random sequence covers carry-out at many multiplicand bit patterns. Starts are also issued during busy, in the done cycle and just before a mid-operation reset, to separate accepted, ignored and aborted requests.

// File: rtl/smul_pkg.sv
package smul_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIX  = 2'd2
    } smul_state_e;
endpackage

// File: rtl/smul_mag.sv
// Two's-complement operand to unsigned magnitude plus sign flag.
module smul_mag #(
    parameter int W = 8
) (
    input  logic [W-1:0] val,
    output logic [W-1:0] mag,
    output logic         neg
);
    always_comb begin
        neg = val[W-1];
        mag = neg ? (~val + W'(1)) : val;
    end
endmodule

// File: rtl/smul_step.sv
// One add-and-shift iteration of the unsigned core.
module smul_step #(
    parameter int W = 8
) (
    input  logic [2*W-1:0] acc,
    input  logic [W-1:0]   mcand,
    output logic [2*W-1:0] nxt
);
    logic [W:0] sum;
    logic [W:0] addend;

    always_comb begin
        addend = acc[0] ? {1'b0, mcand} : '0;
        sum    = {1'b0, acc[2*W-1:W]} + addend;
        nxt    = {sum, acc[W-1:1]};
    end
endmodule

// File: rtl/smul_sign_fix.sv
// Conditional negation of the unsigned product.
module smul_sign_fix #(
    parameter int W = 16
) (
    input  logic [W-1:0] val,
    input  logic         neg,
    output logic [W-1:0] res
);
    always_comb res = neg ? (~val + W'(1)) : val;
endmodule

// File: rtl/smul_serial.sv
module smul_serial
    import smul_pkg::*;
#(
    parameter int N = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic [N-1:0]   op_a,
    input  logic [N-1:0]   op_b,
    output logic           busy,
    output logic           done,
    output logic [2*N-1:0] product
);
    localparam int PW = 2 * N;
    localparam int CW = $clog2(N + 1);
    localparam logic [CW-1:0] LAST_ITER = CW'(N - 1);

    smul_state_e state_q, state_d;

    logic [PW-1:0] acc_q;
    logic [N-1:0]  mcand_q;
    logic          neg_q;
    logic [CW-1:0] iter_q;
    logic          done_q;

    logic [N-1:0]  a_mag, b_mag;
    logic          a_neg, b_neg;
    logic [PW-1:0] step_nxt;
    logic [PW-1:0] fix_res;

    smul_mag #(.W(N)) u_mag_a (.val(op_a), .mag(a_mag), .neg(a_neg));
    smul_mag #(.W(N)) u_mag_b (.val(op_b), .mag(b_mag), .neg(b_neg));

    smul_step #(.W(N)) u_step (.acc(acc_q), .mcand(mcand_q), .nxt(step_nxt));

    smul_sign_fix #(.W(PW)) u_fix (.val(acc_q), .neg(neg_q), .res(fix_res));

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_RUN;
            ST_RUN:  if (iter_q == LAST_ITER) state_d = ST_FIX;
            ST_FIX:  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Datapath and outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q   <= '0;
            mcand_q <= '0;
            neg_q   <= 1'b0;
            iter_q  <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        acc_q   <= {{N{1'b0}}, a_mag};
                        mcand_q <= b_mag;
                        neg_q   <= a_neg ^ b_neg;
                        iter_q  <= '0;
                    end
                end
                ST_RUN: begin
                    acc_q  <= step_nxt;
                    iter_q <= iter_q + CW'(1);
                end
                ST_FIX: begin
                    acc_q  <= fix_res;
                    done_q <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign busy    = (state_q != ST_IDLE);
    assign done    = done_q;
    assign product = acc_q;
endmodule

// File: rtl/smul_serial_chk.sv
module smul_serial_chk #(
    parameter int N = 8
) (
    input logic           clk,
    input logic           rst,
    input logic           start,
    input logic [N-1:0]   op_a,
    input logic [N-1:0]   op_b,
    input logic           busy,
    input logic           done,
    input logic [2*N-1:0] product
);
    logic [N-1:0]   cap_a, cap_b;
    logic [2*N-1:0] model_p;
    int             busy_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_a    <= '0;
            cap_b    <= '0;
            busy_cnt <= 0;
        end else begin
            if (start && !busy) begin
                cap_a <= op_a;
                cap_b <= op_b;
            end
            busy_cnt <= busy ? busy_cnt + 1 : 0;
        end
    end

    always_comb model_p = $signed({{N{cap_a[N-1]}}, cap_a}) * $signed({{N{cap_b[N-1]}}, cap_b});

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (!busy && !done && product == '0));

    p_start_rise_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start));

    p_busy_len_r3: assert property (@(posedge clk) disable iff (rst)
        ($fell(busy) && busy_cnt != 0) |-> (busy_cnt == N + 1 && done));

    p_done_pulse_r3: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_not_both_r3: assert property (@(posedge clk) disable iff (rst)
        !(busy && done));

    p_product_r4: assert property (@(posedge clk) disable iff (rst)
        done |-> product == model_p);

    p_start_ignored_r6: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(busy));

    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> $stable(product));
endmodule

bind smul_serial smul_serial_chk #(.N(N)) u_chk (
    .clk(clk), .rst(rst), .start(start), .op_a(op_a), .op_b(op_b),
    .busy(busy), .done(done), .product(product)
);

// File: tb/smul_serial_tb_top.sv
module smul_serial_tb_top;
    localparam int N = 8;
    localparam int PW = 2 * N;
    localparam time CLK_PERIOD = 10ns;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [N-1:0]  op_a = '0;
    logic [N-1:0]  op_b = '0;
    logic          busy;
    logic          done;
    logic [PW-1:0] product;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    logic [PW-1:0] exp_q[$];
    string         tag_q[$];
    logic [PW-1:0] last_exp;
    bit            prev_done = 1'b0;

    smul_serial #(.N(N)) dut_i (
        .clk(clk), .rst(rst), .start(start), .op_a(op_a), .op_b(op_b),
        .busy(busy), .done(done), .product(product)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic logic [PW-1:0] ref_mul(input logic [N-1:0] a, input logic [N-1:0] b);
        longint x;
        x = longint'($signed(a)) * longint'($signed(b));
        return x[PW-1:0];
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp_v);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp_v);
        end
    endtask

    // Monitor: pops the scoreboard on each done pulse
    always @(negedge clk) begin
        if (!rst) begin
            if (done) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R6 unexpected done", longint'(product), 0);
                end else begin
                    logic [PW-1:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(product == e, t, longint'(product), longint'(e));
                end
                check(!busy, "R3 busy with done", longint'(busy), 0);
                check(!prev_done, "R3 done width", 2, 1);
            end
            prev_done = done;
        end else begin
            prev_done = 1'b0;
        end
    end

    // Driver: one operation, optionally poking start while busy
    task automatic run_op(input logic [N-1:0] a, input logic [N-1:0] b,
                          input string tag, input bit poke);
        int lat;
        while (busy) @(negedge clk);
        op_a = a;
        op_b = b;
        start = 1'b1;
        last_exp = ref_mul(a, b);
        exp_q.push_back(last_exp);
        tag_q.push_back(tag);
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R2 busy after start", longint'(busy), 1);
        lat = 1;
        while (!done && lat < 100) begin
            if (poke && lat == 3) begin
                op_a = ~a;
                op_b = b + N'(5);
                start = 1'b1;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            lat++;
        end
        start = 1'b0;
        check(lat == N + 2, "R3 latency", longint'(lat), longint'(N + 2));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        repeat (3) @(negedge clk);
        check(busy == 1'b0 && done == 1'b0 && product == '0, "R1 reset state",
              longint'(product), 0);
        rst = 1'b0;
        @(negedge clk);

        // R8 worked examples
        run_op(8'd118, 8'd99, "R8 118x99", 1'b0);
        check(product == 16'h2DA2, "R8 value 0x2DA2", longint'(product), 16'h2DA2);
        run_op(-8'sd118, -8'sd99, "R8 -118x-99", 1'b0);
        check(product == 16'h2DA2, "R8 neg pair 0x2DA2", longint'(product), 16'h2DA2);
        run_op(8'd118, -8'sd99, "R8 118x-99", 1'b0);
        check(product == 16'hD25E, "R8 mixed 0xD25E", longint'(product), 16'hD25E);

        // R4 sign quadrants and small magnitudes
        run_op(-8'sd7, 8'd13, "R4 neg x pos", 1'b0);
        run_op(8'd0, -8'sd55, "R4 zero x neg", 1'b0);
        run_op(-8'sd1, -8'sd1, "R4 -1x-1", 1'b0);
        run_op(8'd127, 8'd127, "R4 max x max", 1'b0);

        // R5 most negative operand
        run_op(8'h80, 8'h80, "R5 min x min", 1'b0);
        check(product == 16'h4000, "R5 16384", longint'(product), 16'h4000);
        run_op(8'h80, 8'd127, "R5 min x max", 1'b0);
        check(product == 16'hC080, "R5 -16256", longint'(product), 16'hC080);
        run_op(8'd1, 8'h80, "R5 one x min", 1'b0);

        // R7 hold after done
        repeat (5) @(negedge clk);
        check(product == last_exp, "R7 hold", longint'(product), longint'(last_exp));

        // R6 start while busy is ignored
        run_op(8'd45, -8'sd10, "R6 poked op", 1'b1);
        repeat (N + 4) @(negedge clk);
        check(exp_q.size() == 0 && product == last_exp, "R6 no extra op",
              longint'(product), longint'(last_exp));

        // R9 back-to-back starts in the done cycle
        run_op(8'd3, 8'd5, "R9 first", 1'b0);
        check(!busy && done, "R9 start in done cycle", longint'(busy), 0);
        run_op(-8'sd20, 8'd6, "R9 second", 1'b0);

        // R1 reset in mid-operation
        while (busy) @(negedge clk);
        op_a = 8'd50; op_b = 8'd50; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check(!busy && !done && product == '0, "R1 mid-op reset", longint'(product), 0);
        rst = 1'b0;
        @(negedge clk);
        repeat (N + 3) @(negedge clk);
        check(!done && !busy, "R1 no done after abort", longint'(done), 0);

        // R4 pseudo-random sweep
        lfsr = 16'hACE1;
        for (int i = 0; i < 150; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            run_op(lfsr[7:0], lfsr[15:8], "R4 sweep", 1'b0);
        end

        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R3 all results seen", longint'(exp_q.size()), 0);
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end
endmodule